// File: doc/BRIEF.md
# Tamper Timestamp Event Queue

This block watches three external tamper pins. Each pin passes through its own glitch filter, set by a polarity bit, a duration count and a select that picks one of four filter clock enables. When a pin has stayed at its active level long enough, the event is confirmed. A timestamp is then pushed into an eight-entry FIFO. The timestamp holds month, day, hour, minute and second from the calendar inputs, plus the index of the pin that fired. The year is deliberately left out. Software reads it from the calendar and is expected to drain the queue often enough that this is safe.

Software pops an entry with two successive reads of one 16-bit read port. The first read returns the date half and the second returns the time-and-source half. The entry leaves the queue only when the second half is read. Calendar counting and the filter clock dividers sit outside the block: the current time fields and the filter clock enables arrive as inputs. The tamper pins are assumed to be synchronous to `clk` already.

Top module: `tamper_evq`

## Requirements
- R1: After reset the queue is empty, `q_rdata` reads 0, `q_ovf` is 0, and every pin filter is configured as active-high, duration 0, clock enable 0.
- R2: A pin is active when its level XOR its polarity bit is 1 (polarity 0 means active-high, polarity 1 means active-low). An event is confirmed only if the pin is sampled active at DUR clock edges on which its selected filter clock enable is high, and is still active at the clock edge after that. Any inactive sample clears the count.
- R3: The queue holds 8 entries. An event that arrives while it is full is dropped and sets `q_ovf`. `q_ovf` stays set until reset.
- R4: When the queue is not empty and no half has been read, `q_rdata` gives hour in bits 4:0, day in bits 9:5 and month in bits 13:10. Bits 15:14 read 0.
- R5: After the first half has been read, `q_rdata` gives second in bits 5:0, minute in bits 11:6 and pin index (0 to 2) in bits 14:12. Bit 15 reads 0.
- R6: A `q_rd` pulse on the first half only advances to the second half. The entry is removed by the `q_rd` pulse on the second half.
- R7: While the queue is empty, `q_rdata` is 0 and a `q_rd` pulse changes nothing.
- R8: One unbroken active level produces exactly one entry, however long it lasts.
- R9: A write to `cfg01_wdata` sets pin 0 from bits 6:0 and pin 1 from bits 14:8. A write to `cfg2_wdata` sets pin 2 from bits 6:0. Inside each 7-bit field, bit 0 is polarity, bits 4:1 are duration and bits 6:5 select the filter clock enable.
- R10: Events confirmed on the same cycle are stored one per cycle in ascending pin index order.
- R11: Entries are read out in the order they were stored. Each entry carries the time inputs present when it was stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tamp_pin | input | 3 | Tamper pins, one bit per source |
| flt_clk_en | input | 4 | Filter clock enables, one chosen per pin |
| cfg01_we | input | 1 | Write strobe for the pin 0/1 filter settings |
| cfg01_wdata | input | 16 | Pin 0 settings in bits 6:0, pin 1 settings in bits 14:8 |
| cfg2_we | input | 1 | Write strobe for the pin 2 filter settings |
| cfg2_wdata | input | 8 | Pin 2 settings in bits 6:0 |
| now_mon | input | 4 | Current month |
| now_day | input | 5 | Current day |
| now_hour | input | 5 | Current hour |
| now_min | input | 6 | Current minute |
| now_sec | input | 6 | Current second |
| q_rd | input | 1 | Read strobe: consumes the half shown on q_rdata |
| q_rdata | output | 16 | Current half of the oldest entry, 0 when empty |
| q_ovf | output | 1 | Sticky flag: an event was dropped on a full queue |

## Verification
The bench checks the duration boundary from both sides:
- A pulse one filter sample too short must leave no entry. A filter that counts one sample early would record it.
- A long hold must leave exactly one entry. A level-triggered design would flood the queue.

It sends a ninth event into a full queue. The first eight entries must come back intact and the overflow flag must stay set. A design that overwrote entries or cleared the flag would fail there.

It fires all three pins at once to catch lost or reordered simultaneous events. It reads the first half twice across idle cycles to catch a pop on the wrong half. Finally, randomized single events with a reference queue model check field packing and ordering.

// File: rtl/tevq_pkg.sv
// Package: shared types for the tamper timestamp event queue.
// Assumes three tamper sources and four filter clock enables.
package tevq_pkg;
    localparam int NUM_SRC = 3;
    localparam int NCLK    = 4;
    localparam int DUR_W   = 4;
    localparam int SEL_W   = $clog2(NCLK);
    localparam int IDX_W   = 3;

    // Per-pin filter settings; packed so bit 0 is polarity.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [DUR_W-1:0] dur;
        logic             pol;
    } flt_cfg_t;

    localparam int CFG_W = $bits(flt_cfg_t);

    // One queued timestamp (year omitted on purpose).
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [3:0]       mon;
        logic [4:0]       day;
        logic [4:0]       hour;
        logic [5:0]       mnt;
        logic [5:0]       sec;
    } stamp_t;

    localparam int STAMP_W = $bits(stamp_t);
endpackage

// File: rtl/tevq_filter.sv
// Module: tevq_filter
// Glitch filter for one tamper pin. Counts qualified filter clock
// enables while the pin is active and emits a single-cycle event once
// the count equals the programmed duration and the pin is still active.
// Assumes the pin is already synchronous to clk.
module tevq_filter
    import tevq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  flt_cfg_t         cfg,
    input  logic [NCLK-1:0]  clk_en,
    output logic             evt
);
    logic             act;
    logic             tick;
    logic             armed_hit;
    logic [DUR_W-1:0] cnt;

    // Active level after polarity, and the selected enable.
    always_comb begin
        act  = pin ^ cfg.pol;
        tick = clk_en[cfg.sel];
    end

    // Counts active samples; fires once per unbroken active level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            armed_hit <= 1'b0;
            evt       <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (!act) begin
                cnt       <= '0;
                armed_hit <= 1'b0;
            end else if (!armed_hit) begin
                if (cnt == cfg.dur) begin
                    armed_hit <= 1'b1;
                    evt       <= 1'b1;
                end else if (tick) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tevq_fifo.sv
// Module: tevq_fifo
// Synchronous FIFO with occupancy count. A push while full is ignored
// (the caller records the drop); a pop while empty is ignored.
// Assumes DEPTH is a power of two.
module tevq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             din,
    input  logic                     pop,
    output logic [W-1:0]             dout,
    output logic [$clog2(DEPTH):0]   cnt,
    output logic                     full,
    output logic                     empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          push_ok;
    logic          pop_ok;

    // Status and accepted operations.
    always_comb begin
        full    = (cnt == (AW+1)'(DEPTH));
        empty   = (cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dout    = mem[rptr];
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end
endmodule

// File: rtl/tamper_evq.sv
// Module: tamper_evq (top)
// Three filtered tamper pins feed a timestamp FIFO read out as two
// 16-bit halves from one port. Simultaneous events wait in a pending
// vector and are stored lowest index first, one per cycle; the stamp is
// taken from the time inputs on the store cycle. Assumes time inputs
// are stable across the few cycles between confirmation and store.
module tamper_evq
    import tevq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   tamp_pin,
    input  logic [NCLK-1:0]      flt_clk_en,
    input  logic                 cfg01_we,
    input  logic [15:0]          cfg01_wdata,
    input  logic                 cfg2_we,
    input  logic [7:0]           cfg2_wdata,
    input  logic [3:0]           now_mon,
    input  logic [4:0]           now_day,
    input  logic [4:0]           now_hour,
    input  logic [5:0]           now_min,
    input  logic [5:0]           now_sec,
    input  logic                 q_rd,
    output logic [15:0]          q_rdata,
    output logic                 q_ovf
);
    localparam int CW = $clog2(DEPTH) + 1;

    flt_cfg_t             flt_cfg [NUM_SRC];
    logic [NUM_SRC-1:0]   flt_evt;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   grant;
    logic [IDX_W-1:0]     grant_idx;
    logic                 push;
    stamp_t               wr_stamp;
    stamp_t               rd_stamp;
    logic [CW-1:0]        fifo_cnt;
    logic                 fifo_full;
    logic                 fifo_empty;
    logic                 rd_half;
    logic                 pop;

    // Filter settings registers; pins 0 and 1 share one write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) flt_cfg[i] <= '0;
        end else begin
            if (cfg01_we) begin
                flt_cfg[0] <= cfg01_wdata[CFG_W-1:0];
                flt_cfg[1] <= cfg01_wdata[8 +: CFG_W];
            end
            if (cfg2_we) flt_cfg[2] <= cfg2_wdata[CFG_W-1:0];
        end
    end

    // One glitch filter per tamper pin.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flt
        tevq_filter u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (tamp_pin[g]),
            .cfg    (flt_cfg[g]),
            .clk_en (flt_clk_en),
            .evt    (flt_evt[g])
        );
    end

    // Lowest-index pending event wins the store slot.
    always_comb begin
        grant     = pend & (~pend + 1'b1);
        grant_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) grant_idx = IDX_W'(i);
        end
        push     = |pend;
        wr_stamp = '{idx: grant_idx, mon: now_mon, day: now_day,
                     hour: now_hour, mnt: now_min, sec: now_sec};
    end

    // Pending events: set by filters, cleared when stored or dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~grant) | flt_evt;
    end

    // Sticky record of an event dropped on a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q_ovf <= 1'b0;
        else if (push && fifo_full) q_ovf <= 1'b1;
    end

    tevq_fifo #(.W(STAMP_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_stamp),
        .pop   (pop),
        .dout  (rd_stamp),
        .cnt   (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // Half selector: pop only on the read of the second half.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_half <= 1'b0;
        else if (q_rd && !fifo_empty) rd_half <= ~rd_half;
    end

    // Read mux: date half, then time-and-source half, zero when empty.
    always_comb begin
        pop = q_rd && rd_half && !fifo_empty;
        if (fifo_empty)   q_rdata = '0;
        else if (rd_half) q_rdata = {1'b0, rd_stamp.idx, rd_stamp.mnt, rd_stamp.sec};
        else              q_rdata = {2'b00, rd_stamp.mon, rd_stamp.day, rd_stamp.hour};
    end
endmodule

// File: rtl/tevq_chk.sv
// Module: tevq_chk
// Protocol checks for tamper_evq, attached with bind.
module tevq_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4,
    parameter int NS    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_rd,
    input  logic [15:0]   q_rdata,
    input  logic          q_ovf,
    input  logic [CW-1:0] cnt,
    input  logic          half,
    input  logic [NS-1:0] evt
);
    // R3: occupancy never exceeds capacity.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R3: overflow flag is sticky.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf |=> q_ovf);

    // R6: reading the first half never removes an entry.
    p_no_early_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_rd && !half && cnt != '0) |=> (cnt >= $past(cnt)));

    // R7: empty queue reads zero.
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (q_rdata == 16'h0000));

    // R7: no half is pending while empty.
    p_half_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !half);

    // R8: a filter event never lasts two cycles.
    p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((evt & $past(evt)) == '0));

    // R5: stored source index is a real pin.
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (half && cnt != '0) |-> (q_rdata[14:12] < 3'(NS)));
endmodule

bind tamper_evq tevq_chk #(.DEPTH(DEPTH), .CW(CW), .NS(tevq_pkg::NUM_SRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_rd    (q_rd),
    .q_rdata (q_rdata),
    .q_ovf   (q_ovf),
    .cnt     (fifo_cnt),
    .half    (rd_half),
    .evt     (flt_evt)
);

// File: tb/sim_tamper_evq.sv
module sim_tamper_evq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tamp_pin = 3'b000;
    logic [3:0]  flt_clk_en = 4'b0001;
    logic        cfg01_we = 1'b0;
    logic [15:0] cfg01_wdata = '0;
    logic        cfg2_we = 1'b0;
    logic [7:0]  cfg2_wdata = '0;
    logic [3:0]  now_mon = 4'd1;
    logic [4:0]  now_day = 5'd1;
    logic [4:0]  now_hour = '0;
    logic [5:0]  now_min = '0;
    logic [5:0]  now_sec = '0;
    logic        q_rd = 1'b0;
    logic [15:0] q_rdata;
    logic        q_ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [1:0] ecnt = '0;
    logic [2:0] idle_lvl = 3'b000;

    // Reference queue model
    logic [15:0] m_hi [8];
    logic [15:0] m_lo [8];
    int m_n = 0;

    tamper_evq u0 (.*);

    always #10 clk = ~clk;

    // Filter clock enables: en0 always, en1 every 4th, en2 every 2nd, en3 never.
    always @(negedge clk) begin
        ecnt = ecnt + 1'b1;
        flt_clk_en = {1'b0, ecnt[0], ecnt == 2'd0, 1'b1};
    end

    function automatic logic [15:0] exp_hi(input logic [3:0] m, input logic [4:0] d, input logic [4:0] h);
        return {2'b00, m, d, h};
    endfunction

    function automatic logic [15:0] exp_lo(input logic [2:0] i, input logic [5:0] mi, input logic [5:0] s);
        return {1'b0, i, mi, s};
    endfunction

    function automatic logic [6:0] fcfg(input logic [1:0] sel, input logic [3:0] dur, input logic pol);
        return {sel, dur, pol};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr01(input logic [6:0] c0, input logic [6:0] c1);
        @(negedge clk);
        cfg01_wdata = {1'b0, c1, 1'b0, c0};
        cfg01_we = 1'b1;
        @(negedge clk);
        cfg01_we = 1'b0;
    endtask

    task automatic wr2(input logic [6:0] c2);
        @(negedge clk);
        cfg2_wdata = {1'b0, c2};
        cfg2_we = 1'b1;
        @(negedge clk);
        cfg2_we = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] v);
        @(negedge clk);
        v = q_rdata;
        q_rd = 1'b1;
        @(negedge clk);
        q_rd = 1'b0;
    endtask

    task automatic set_time(input logic [3:0] m, input logic [4:0] d, input logic [4:0] h,
                            input logic [5:0] mi, input logic [5:0] s);
        @(negedge clk);
        now_mon = m; now_day = d; now_hour = h; now_min = mi; now_sec = s;
    endtask

    task automatic rand_time();
        set_time(4'(1 + $urandom % 12), 5'(1 + $urandom % 28), 5'($urandom % 24),
                 6'($urandom % 60), 6'($urandom % 60));
    endtask

    // Hold pin i active for n cycles, then idle long enough to drain.
    task automatic pulse(input int i, input int n);
        @(negedge clk);
        tamp_pin[i] = ~idle_lvl[i];
        repeat (n) @(negedge clk);
        tamp_pin[i] = idle_lvl[i];
        repeat (6) @(negedge clk);
    endtask

    task automatic model_push(input int i);
        if (m_n < 8) begin
            m_hi[m_n] = exp_hi(now_mon, now_day, now_hour);
            m_lo[m_n] = exp_lo(3'(i), now_min, now_sec);
            m_n++;
        end
    endtask

    task automatic model_pop(input string req);
        logic [15:0] h, l;
        rd_word(h);
        rd_word(l);
        if (m_n == 0) begin
            chk(req, h, 16'h0000);
            chk(req, l, 16'h0000);
        end else begin
            chk(req, h, m_hi[0]);
            chk(req, l, m_lo[0]);
            for (int k = 0; k < 7; k++) begin
                m_hi[k] = m_hi[k+1];
                m_lo[k] = m_lo[k+1];
            end
            m_n--;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", q_rdata, 16'h0000);
        chk("R1 ovf", {15'b0, q_ovf}, 16'h0000);

        // R7 empty read has no effect
        rd_word(v);
        chk("R7 empty read", v, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R7 after empty read", q_rdata, 16'h0000);

        // R2/R9 pin 0: active-high, dur 3, en0
        wr01(fcfg(2'd0, 4'd3, 1'b0), fcfg(2'd3, 4'd15, 1'b0));
        set_time(4'd7, 5'd19, 5'd13, 6'd42, 6'd5);
        pulse(0, 3);
        chk("R2 short pulse ignored", q_rdata, 16'h0000);
        pulse(0, 40);
        // R8: long hold gave one entry; R6: first half read twice
        chk("R4 first half", q_rdata, exp_hi(4'd7, 5'd19, 5'd13));
        rd_word(v);
        repeat (3) @(negedge clk);
        chk("R6 second half held", q_rdata, exp_lo(3'd0, 6'd42, 6'd5));
        rd_word(v);
        chk("R5 second half", v, exp_lo(3'd0, 6'd42, 6'd5));
        chk("R8 single entry", q_rdata, 16'h0000);

        // R2/R9 pin 1: active-low, dur 2, en1 (every 4th cycle)
        idle_lvl[1] = 1'b1;
        tamp_pin[1] = 1'b1;
        wr01(fcfg(2'd0, 4'd3, 1'b0), fcfg(2'd1, 4'd2, 1'b1));
        set_time(4'd12, 5'd31, 5'd23, 6'd59, 6'd59);
        pulse(1, 3);
        chk("R2 active-low short ignored", q_rdata, 16'h0000);
        pulse(1, 20);
        model_push(1);
        model_pop("R9 pin1 active-low");
        // park pin 1 back to active-high without an event
        wr01(fcfg(2'd0, 4'd0, 1'b0), fcfg(2'd3, 4'd15, 1'b1));
        tamp_pin[1] = 1'b0;
        idle_lvl[1] = 1'b0;
        wr01(fcfg(2'd0, 4'd0, 1'b0), fcfg(2'd0, 4'd0, 1'b0));
        wr2(fcfg(2'd0, 4'd0, 1'b0));
        repeat (4) @(negedge clk);
        chk("R9 reconfigure no event", q_rdata, 16'h0000);

        // R10 all three pins at once
        set_time(4'd3, 5'd4, 5'd5, 6'd6, 6'd7);
        @(negedge clk);
        tamp_pin = 3'b111;
        repeat (3) @(negedge clk);
        tamp_pin = 3'b000;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 3; i++) model_push(i);
        for (int i = 0; i < 3; i++) model_pop("R10 simultaneous order");
        chk("R10 drained", q_rdata, 16'h0000);

        // R3 overflow with pin 2, nine events at distinct times
        for (int k = 0; k < 9; k++) begin
            rand_time();
            model_push(2);
            pulse(2, 2);
        end
        chk("R3 ovf set", {15'b0, q_ovf}, 16'h0001);
        for (int k = 0; k < 8; k++) model_pop("R3 full queue kept");
        chk("R3 ninth dropped", q_rdata, 16'h0000);
        chk("R3 ovf sticky", {15'b0, q_ovf}, 16'h0001);

        // R11 random single events against the model
        for (int k = 0; k < 40; k++) begin
            int p;
            int d;
            p = int'($urandom % 3);
            d = int'($urandom % 4);
            if (p == 2) wr2(fcfg(2'd0, 4'(d), 1'b0));
            else        wr01(fcfg(2'd0, p == 0 ? 4'(d) : 4'd0, 1'b0),
                             fcfg(2'd0, p == 1 ? 4'(d) : 4'd0, 1'b0));
            rand_time();
            if (m_n < 8) model_push(p);
            pulse(p, d + 3);
            if (($urandom % 2) == 0) model_pop("R11 random order");
        end
        while (m_n > 0) model_pop("R11 random drain");
        chk("R11 final empty", q_rdata, 16'h0000);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule